// File: doc/BRIEF.md
# DDR Calibration Launch and Status Register

This block is the software-facing control word for the two DDR bus calibration procedures of a memory buffer. Firmware writes one 32-bit word. The top bit asks for a run. The remaining bits name the procedure. The block decodes the word and raises a request to the matching calibration engine. It keeps the top bit set while that engine works and clears it in hardware when the engine acknowledges. Firmware learns that a run has finished by polling the top bit.

Two procedures are defined. Code 0xC runs receive-enable calibration, which locates the strobe preamble. Code 0x5 runs strobe delay calibration, which centres the strobe in the data eye. Both must finish, receive-enable first, before captured read data can be trusted. Each engine issues its own write and read traffic, so DRAM contents are lost during a run. The engines sit outside this block and are seen only as request/acknowledge pairs.

The register also reports an error bit for undefined codes and a per-procedure completion flag for each engine. A results-valid bit sets only when the two procedures have completed in the right order.

Top module: `ddr_cal_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the readback word is 0x00000000 and no engine request is raised.
- R2: A write with bit 31 set, taken while the block is idle, starts a run if bits 30:0 equal 0x0000000C or 0x00000005. From the next cycle bit 31 reads 1. Code 0xC raises eng_req[0] (receive-enable) and code 0x5 raises eng_req[1] (strobe delay).
- R3: A write with bit 31 clear, taken while idle, only stores bits 3:0 into readback bits 3:0. It starts nothing. Bit 31 never sets except through an accepted write.
- R4: Bit 31 clears on the clock edge that samples the acknowledge of the running engine. That edge also sets the engine's completion flag: bit 10 for receive-enable, bit 11 for strobe delay.
- R5: At most one request is high at any time. It stays high, unchanged, until its acknowledge is sampled.
- R6: A start write whose bits 30:0 match neither code sets error bit 8. This includes a write with a valid code but a nonzero bit among bits 30:4. Bit 31 then reads 1 for exactly one cycle, no request is raised, and bit 9 keeps its value. A later start with a defined code clears bit 8.
- R7: Any write taken while bit 31 reads 1 is ignored: no field of the readback changes.
- R8: An acknowledge from an engine that is not currently requested has no effect on the readback.
- R9: Bit 9 (results valid) sets when strobe delay calibration finishes while the receive-enable flag (bit 10) is set. Starting a defined calibration clears bit 9 and that calibration's own completion flag.
- R10: Asserting reset during a run aborts it. The readback returns to 0x00000000 and the request drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write strobe, one cycle per write |
| cfg_wr_data | input | DATA_W | Word written to the control register |
| cfg_rd_data | output | DATA_W | Current readback of the control/status register |
| eng_req | output | NUM_ENG | Run request, one bit per calibration engine |
| eng_ack | input | NUM_ENG | Completion pulse, one bit per calibration engine |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 4-bit selection field, two engines and codes 0xC and 0x5. The bench engine models acknowledge after 5 and 8 cycles, so a full receive-enable then strobe-delay sequence, reruns in both orders, and the ordering rule for results-valid all fit in a short run. Manual acknowledge pulses and writes placed inside a run reach the ignore paths for stray acknowledges and busy-time writes. A reset asserted mid-run checks the abort path.

// File: rtl/ddr_cal_pkg.sv
package ddr_cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_RUN  = 2'd1,
    CAL_BAD  = 2'd2
  } cal_state_e;
endpackage

// File: rtl/ddr_cal_rst_sync.sv
module ddr_cal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/ddr_cal_decode.sv
module ddr_cal_decode #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_ENG = 2,
  parameter logic [NUM_ENG*SEL_W-1:0] ENG_CODES = {4'h5, 4'hC}
) (
  input  logic [DATA_W-2:0]  wr_low,
  output logic [NUM_ENG-1:0] hit
);
  localparam int unsigned LOW_W = DATA_W - 1;

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_match
    logic [LOW_W-1:0] code_ext;
    assign code_ext = LOW_W'(ENG_CODES[e*SEL_W +: SEL_W]);
    assign hit[e]   = (wr_low == code_ext);
  end
endmodule

// File: rtl/ddr_cal_fsm.sv
module ddr_cal_fsm
  import ddr_cal_pkg::*;
#(
  parameter int unsigned NUM_ENG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_start,
  input  logic [NUM_ENG-1:0] hit,
  input  logic [NUM_ENG-1:0] eng_ack,
  output logic               idle,
  output logic               busy,
  output logic               accept,
  output logic [NUM_ENG-1:0] eng_req,
  output logic [NUM_ENG-1:0] eng_done
);
  cal_state_e        state_q, state_d;
  logic [NUM_ENG-1:0] active_q, active_d;
  logic              act_en;

  assign idle     = (state_q == CAL_IDLE);
  assign busy     = !idle;
  assign accept   = idle && wr_start;
  assign eng_req  = (state_q == CAL_RUN) ? active_q : '0;
  assign eng_done = eng_req & eng_ack;

  always_comb begin
    state_d  = state_q;
    active_d = active_q;
    act_en   = 1'b0;
    unique case (state_q)
      CAL_IDLE: begin
        if (accept) begin
          act_en = 1'b1;
          if (|hit) begin
            state_d  = CAL_RUN;
            active_d = hit;
          end else begin
            state_d  = CAL_BAD;
            active_d = '0;
          end
        end
      end
      CAL_RUN: begin
        if (|eng_done) begin
          state_d  = CAL_IDLE;
          active_d = '0;
          act_en   = 1'b1;
        end
      end
      CAL_BAD: begin
        state_d = CAL_IDLE;
      end
      default: begin
        state_d  = CAL_IDLE;
        active_d = '0;
        act_en   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CAL_IDLE;
      active_q <= '0;
    end else begin
      state_q <= state_d;
      if (act_en) active_q <= active_d;
    end
  end
endmodule

// File: rtl/ddr_cal_status.sv
module ddr_cal_status #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_ENG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_sel,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic               accept,
  input  logic [NUM_ENG-1:0] hit,
  input  logic [NUM_ENG-1:0] eng_done,
  output logic [SEL_W-1:0]   sel_q,
  output logic               err_q,
  output logic               valid_q,
  output logic [NUM_ENG-1:0] flag_q
);
  logic               defined_start;
  logic               err_en, err_d;
  logic               valid_en, valid_d;
  logic               prior_ok;
  logic [NUM_ENG-1:0] flag_d;

  assign defined_start = accept && (|hit);
  assign err_en        = accept;
  assign err_d         = !(|hit);

  always_comb begin
    prior_ok = 1'b1;
    for (int e = 0; e < NUM_ENG - 1; e++) begin
      prior_ok = prior_ok & flag_q[e];
    end
  end

  always_comb begin
    valid_en = 1'b0;
    valid_d  = valid_q;
    if (defined_start) begin
      valid_en = 1'b1;
      valid_d  = 1'b0;
    end else if (eng_done[NUM_ENG-1] && prior_ok) begin
      valid_en = 1'b1;
      valid_d  = 1'b1;
    end
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_flag
    always_comb begin
      flag_d[e] = flag_q[e];
      if (accept && hit[e]) flag_d[e] = 1'b0;
      else if (eng_done[e]) flag_d[e] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
      flag_q  <= '0;
    end else begin
      if (load_sel) sel_q <= wr_sel;
      if (err_en) err_q <= err_d;
      if (valid_en) valid_q <= valid_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/ddr_cal_ctrl.sv
module ddr_cal_ctrl #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned NUM_ENG   = 2,
  parameter logic [NUM_ENG*SEL_W-1:0] ENG_CODES = {4'h5, 4'hC},
  parameter int unsigned ERR_BIT   = 8,
  parameter int unsigned VALID_BIT = 9,
  parameter int unsigned FLAG_LSB  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [DATA_W-1:0]  cfg_wr_data,
  output logic [DATA_W-1:0]  cfg_rd_data,
  output logic [NUM_ENG-1:0] eng_req,
  input  logic [NUM_ENG-1:0] eng_ack
);
  localparam int unsigned START_BIT = DATA_W - 1;

  logic               rst_n_int;
  logic [NUM_ENG-1:0] hit;
  logic               idle, busy, accept;
  logic [NUM_ENG-1:0] eng_done;
  logic [SEL_W-1:0]   sel_q;
  logic               err_q, valid_q;
  logic [NUM_ENG-1:0] flag_q;
  logic               wr_start;
  logic               load_sel;

  assign wr_start = cfg_wr_en && cfg_wr_data[START_BIT];
  assign load_sel = cfg_wr_en && idle;

  ddr_cal_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ddr_cal_decode #(
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W),
    .NUM_ENG   (NUM_ENG),
    .ENG_CODES (ENG_CODES)
  ) u_dec (
    .wr_low (cfg_wr_data[START_BIT-1:0]),
    .hit    (hit)
  );

  ddr_cal_fsm #(
    .NUM_ENG (NUM_ENG)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_start (wr_start),
    .hit      (hit),
    .eng_ack  (eng_ack),
    .idle     (idle),
    .busy     (busy),
    .accept   (accept),
    .eng_req  (eng_req),
    .eng_done (eng_done)
  );

  ddr_cal_status #(
    .SEL_W   (SEL_W),
    .NUM_ENG (NUM_ENG)
  ) u_stat (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_sel (load_sel),
    .wr_sel   (cfg_wr_data[SEL_W-1:0]),
    .accept   (accept),
    .hit      (hit),
    .eng_done (eng_done),
    .sel_q    (sel_q),
    .err_q    (err_q),
    .valid_q  (valid_q),
    .flag_q   (flag_q)
  );

  always_comb begin
    cfg_rd_data                        = '0;
    cfg_rd_data[START_BIT]             = busy;
    cfg_rd_data[SEL_W-1:0]             = sel_q;
    cfg_rd_data[ERR_BIT]               = err_q;
    cfg_rd_data[VALID_BIT]             = valid_q;
    cfg_rd_data[FLAG_LSB +: NUM_ENG]   = flag_q;
  end
endmodule

// File: rtl/ddr_cal_ctrl_chk.sv
module ddr_cal_ctrl_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned NUM_ENG   = 2,
  parameter int unsigned ERR_BIT   = 8,
  parameter int unsigned VALID_BIT = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr_en,
  input logic [DATA_W-1:0]  cfg_wr_data,
  input logic [DATA_W-1:0]  cfg_rd_data,
  input logic [NUM_ENG-1:0] eng_req,
  input logic [NUM_ENG-1:0] eng_ack
);
  localparam int unsigned SB = DATA_W - 1;

  // R2
  accept_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_data[SB] && !cfg_rd_data[SB]) |=> cfg_rd_data[SB]);

  // R3
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rd_data[SB]) |-> $past(cfg_wr_en && cfg_wr_data[SB]));

  // R4
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rd_data[SB]) |-> ($past(|(eng_ack & eng_req)) || $past(cfg_rd_data[ERR_BIT])));

  // R5
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_req));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|eng_req) && !(|(eng_ack & eng_req))) |=> $stable(eng_req));

  // R6
  err_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[ERR_BIT] && cfg_rd_data[SB]) |-> (eng_req == '0));

  // R7
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[SB] && cfg_wr_en) |=> (cfg_rd_data[SEL_W-1:0] == $past(cfg_rd_data[SEL_W-1:0])));

  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rd_data[VALID_BIT]) |-> $past(eng_ack[NUM_ENG-1] && eng_req[NUM_ENG-1]));
endmodule

bind ddr_cal_ctrl ddr_cal_ctrl_chk #(
  .DATA_W    (DATA_W),
  .SEL_W     (SEL_W),
  .NUM_ENG   (NUM_ENG),
  .ERR_BIT   (ERR_BIT),
  .VALID_BIT (VALID_BIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .eng_req     (eng_req),
  .eng_ack     (eng_ack)
);

// File: tb/sim_ddr_cal_ctrl.sv
module sim_ddr_cal_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_RXEN   = 5;
  localparam int LAT_DQSD   = 8;

  typedef struct {
    logic [31:0] rd;
    logic [1:0]  req;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic [1:0]  eng_req;
  logic [1:0]  eng_ack;
  logic [1:0]  ack_auto;
  logic [1:0]  ack_man;
  logic        auto_en;

  int   n_chk;
  int   n_bad;
  exp_t sb_q[$];

  assign eng_ack = ack_auto | ack_man;

  ddr_cal_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .eng_req     (eng_req),
    .eng_ack     (eng_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // engine models: acknowledge a fixed number of cycles after request
  for (genvar e = 0; e < 2; e++) begin : g_eng
    int cnt;
    always @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt = 0;
        ack_auto[e] <= 1'b0;
      end else if (ack_auto[e]) begin
        ack_auto[e] <= 1'b0;
        cnt = 0;
      end else if (eng_req[e] && auto_en) begin
        cnt = cnt + 1;
        if (cnt >= ((e == 0) ? LAT_RXEN : LAT_DQSD)) ack_auto[e] <= 1'b1;
      end else begin
        cnt = 0;
      end
    end
  end

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (cfg_rd_data !== it.rd || eng_req !== it.req) begin
        n_bad++;
        $display("FAIL %s: rd=%h req=%b expected rd=%h req=%b",
                 it.tag, cfg_rd_data, eng_req, it.rd, it.req);
      end
    end
  end

  task automatic expect_now(input logic [31:0] rd, input logic [1:0] req, input string tag);
    exp_t it;
    it.rd = rd; it.req = req; it.tag = tag;
    sb_q.push_back(it);
    #2;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
    cfg_wr_data = '0;
  endtask

  task automatic wait_idle(input string tag);
    bit done;
    done = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      #1;
      if (!cfg_rd_data[31]) begin
        done = 1;
        break;
      end
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s: rd=%h req=%b expected rd=%h req=%b", tag, cfg_rd_data, eng_req, 32'h0, 2'b00);
    end
    @(negedge clk);
  endtask

  task automatic pulse_ack(input logic [1:0] a);
    @(negedge clk);
    ack_man = a;
    @(negedge clk);
    ack_man = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: rd=%h req=%b expected rd=%h req=%b", cfg_rd_data, eng_req, 32'h0, 2'b00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    ack_man = '0; auto_en = 1'b1;
    repeat (3) @(negedge clk);
    expect_now(32'h0, 2'b00, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now(32'h0, 2'b00, "R1 after release");

    // R3: selection only, no start
    wr(32'h0000_000C);
    expect_now(32'h0000_000C, 2'b00, "R3 store without start");
    repeat (3) @(negedge clk);
    expect_now(32'h0000_000C, 2'b00, "R3 no run later");

    // R2 receive-enable launch
    auto_en = 1'b0;
    wr(32'h8000_000C);
    expect_now(32'h8000_000C, 2'b01, "R2 rxen launch");
    // R7 write while busy ignored
    wr(32'h8000_0005);
    expect_now(32'h8000_000C, 2'b01, "R7 busy write ignored");
    wr(32'h0000_0003);
    expect_now(32'h8000_000C, 2'b01, "R7 busy plain write ignored");
    // R8 wrong engine ack
    pulse_ack(2'b10);
    expect_now(32'h8000_000C, 2'b01, "R8 stray ack while running");
    // R5 request held
    repeat (4) @(negedge clk);
    expect_now(32'h8000_000C, 2'b01, "R5 request held");
    auto_en = 1'b1;
    wait_idle("R4 rxen finish");
    expect_now(32'h0000_040C, 2'b00, "R4 rxen done flag");

    // strobe delay
    wr(32'h8000_0005);
    expect_now(32'h8000_0405, 2'b10, "R2 dqs launch");
    wait_idle("R4 dqs finish");
    expect_now(32'h0000_0E05, 2'b00, "R9 valid after both");

    // R8 stray acks while idle
    pulse_ack(2'b11);
    expect_now(32'h0000_0E05, 2'b00, "R8 stray ack idle");

    // R6 undefined code
    wr(32'h8000_0003);
    expect_now(32'h8000_0F03, 2'b00, "R6 bad code busy one cycle");
    @(negedge clk);
    expect_now(32'h0000_0F03, 2'b00, "R6 bad code cleared");

    // R6 error cleared, R9 valid cleared by defined start
    wr(32'h8000_0005);
    expect_now(32'h8000_0405, 2'b10, "R9 dqs restart clears valid");
    wait_idle("R4 dqs rerun finish");
    expect_now(32'h0000_0E05, 2'b00, "R9 valid again");

    // R9 order: rxen rerun leaves valid clear
    wr(32'h8000_000C);
    expect_now(32'h8000_080C, 2'b01, "R9 rxen restart");
    wait_idle("R4 rxen rerun finish");
    expect_now(32'h0000_0C0C, 2'b00, "R9 rxen alone no valid");
    wr(32'h8000_0005);
    wait_idle("R4 dqs third finish");
    expect_now(32'h0000_0E05, 2'b00, "R9 valid after order");

    // R6 reserved bits nonzero
    wr(32'h8000_010C);
    expect_now(32'h8000_0F0C, 2'b00, "R6 reserved bit set");
    @(negedge clk);
    expect_now(32'h0000_0F0C, 2'b00, "R6 reserved bit cleared busy");

    // R10 reset mid-run
    auto_en = 1'b0;
    wr(32'h8000_0005);
    expect_now(32'h8000_0405, 2'b10, "R10 run before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_now(32'h0, 2'b00, "R10 abort on reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    auto_en = 1'b1;
    repeat (4) @(negedge clk);
    expect_now(32'h0, 2'b00, "R10 clean after reset");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule